// File: doc/BRIEF.md
# Buffered I2C Target with Clock Stretching

This block is a 7-bit-addressed I2C target that a local CPU drives through a small register file. Bytes written by the bus controller pass through an internal shift register into a single receive holding register. Bytes to be sent go from a single transmit holding register into the same shift register. Two flags show the state of the two holding registers to software: one shows that the transmit holding register is empty, the other that the receive holding register is full.

When a read is addressed to the block and no transmit byte is waiting, the block holds SCL low until the CPU supplies one. While the controller keeps acknowledging, the block reloads the shift register from the holding register by itself. When the controller does not acknowledge, the block lets go of SDA. A pending transmit byte then stays in the holding register until the block is next addressed for a read.

The CPU side has four byte-wide locations, selected by a 2-bit offset. Offset 0 is control and status. Offset 1 is the own address. Offset 2 is the transmit holding register, which reads back its contents. Offset 3 is the receive holding register. The status byte places its flags as follows: bit 0 enable, bit 1 receive-full, bit 2 transmit-empty, bit 3 address-in-receive, bit 4 last controller acknowledge bit (1 = not acknowledged), bit 5 transmit interrupt. Bits 7:6 read 0. A control write sets enable from bit 0, and a 1 in bit 5 clears the transmit interrupt. The bus lines are open drain: an output of 1 pulls the line low.

Top module: `i2cs_top`

## Requirements
- R1: A CPU write to offset 2 while the block is enabled clears transmit-empty. When that byte moves into the shift register, transmit-empty returns to 1 and the transmit interrupt (status bit 5 and `tx_irq`) is set.
- R2: While enable is 0, transmit-empty reads 1 and receive-full reads 0, including after a write to offset 2. The bus is ignored: no acknowledge is given and both line outputs stay released.
- R3: An address byte is acknowledged only when its upper 7 bits equal the own-address register. A mismatch gets no acknowledge and leaves receive-full and the receive register unchanged.
- R4: After a matched read address has been acknowledged, if transmit-empty is 1 the block holds SCL low and SDA released. A CPU write to offset 2 then releases SCL, and the written byte is sent MSB first.
- R5: In the write direction, the block acknowledges the address byte and every data byte by pulling SDA low for the ninth clock.
- R6: When the controller does not acknowledge a sent byte, the block releases SDA, records bit 4 = 1, and leaves a waiting transmit byte and transmit-empty unchanged. That byte is sent on the next read addressing.
- R7: A matched address (with status bit 3 = 1) or a data byte (with bit 3 = 0) is moved into the receive register and sets receive-full only while receive-full is 0. A later byte does not overwrite it. A CPU read strobe on offset 3 clears receive-full.
- R8: After reset, status reads 0x04, the transmit register reads 0xFF and the receive register reads 0x00.
- R9: When a sent byte is acknowledged and a transmit byte is waiting, the block loads it and goes on without holding SCL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_we | input | 1 | CPU write strobe |
| cpu_re | input | 1 | CPU read strobe (side effect only at offset 3) |
| cpu_addr | input | 2 | Register offset |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Combinational read data for `cpu_addr` |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| tx_irq | output | 1 | Transmit interrupt flag |

## Verification
A line edge reaches the engine after two synchronizer flops and one edge-detect flop, so the engine acts on the third clock after a pin changes. The line outputs follow one clock later, because they are decoded from engine registers. The bench's bus controller keeps every SCL half period at ten clocks and samples SDA in the middle of the high phase, well after the block has settled. CPU strobes take effect at the next edge, and status is read a quarter period after that edge. The per-clock status comparison runs only while the bus and the CPU port are quiet, after a two-cycle settle.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
    localparam int BYTE_W      = 8;
    localparam int SADDR_W     = BYTE_W - 1;
    localparam int CNT_W       = $clog2(BYTE_W + 1);
    localparam int SYNC_STAGES = 2;

    localparam logic [1:0] OFS_CTRL  = 2'd0;
    localparam logic [1:0] OFS_SADDR = 2'd1;
    localparam logic [1:0] OFS_TXD   = 2'd2;
    localparam logic [1:0] OFS_RXD   = 2'd3;

    localparam int ST_EN    = 0;
    localparam int ST_RXBF  = 1;
    localparam int ST_TXBE  = 2;
    localparam int ST_MATCH = 3;
    localparam int ST_RXAK  = 4;
    localparam int ST_TXIF  = 5;

    typedef enum logic [2:0] {
        S_IDLE, S_ADDR, S_ADDR_ACK, S_RX, S_RX_ACK, S_TX, S_TX_ACK, S_HOLD
    } eng_state_e;

    typedef struct packed {
        eng_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic [BYTE_W-1:0] tx;
        logic [BYTE_W-1:0] rx;
        logic              txbe;
        logic              rxbf;
        logic              match;
        logic              rxak;
        logic              rw;
        logic              txif;
    } eng_regs_t;

    typedef struct packed {
        logic               en;
        logic [SADDR_W-1:0] own;
    } cfg_regs_t;
endpackage

// File: rtl/i2cs_line_mon.sv
module i2cs_line_mon
    import i2cs_pkg::*;
#(
    parameter int STAGES = SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    typedef struct packed {
        logic [STAGES-1:0] scl_p;
        logic [STAGES-1:0] sda_p;
        logic              scl_old;
        logic              sda_old;
    } mon_t;

    mon_t m_d, m_q;
    logic scl_s;

    always_comb begin
        m_d         = m_q;
        m_d.scl_p   = {m_q.scl_p[STAGES-2:0], scl_i};
        m_d.sda_p   = {m_q.sda_p[STAGES-2:0], sda_i};
        m_d.scl_old = m_q.scl_p[STAGES-1];
        m_d.sda_old = m_q.sda_p[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '1;
        else        m_q <= m_d;
    end

    assign scl_s    = m_q.scl_p[STAGES-1];
    assign sda_s    = m_q.sda_p[STAGES-1];
    assign scl_rise = scl_s & ~m_q.scl_old;
    assign scl_fall = ~scl_s & m_q.scl_old;
    assign start_ev = scl_s & m_q.scl_old & m_q.sda_old & ~sda_s;
    assign stop_ev  = scl_s & m_q.scl_old & ~m_q.sda_old & sda_s;
endmodule

// File: rtl/i2cs_regs.sv
module i2cs_regs
    import i2cs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_we,
    input  logic               cpu_re,
    input  logic [1:0]         cpu_addr,
    input  logic [BYTE_W-1:0]  cpu_wdata,
    input  logic               txbe,
    input  logic               rxbf,
    input  logic               match,
    input  logic               rxak,
    input  logic               txif,
    input  logic [BYTE_W-1:0]  tx_data,
    input  logic [BYTE_W-1:0]  rx_data,
    output logic               en,
    output logic [SADDR_W-1:0] own_addr,
    output logic [BYTE_W-1:0]  cpu_rdata,
    output logic               tx_wr,
    output logic               rx_rd,
    output logic               txif_clr
);
    cfg_regs_t c_d, c_q;
    logic      unused_wtop;

    assign unused_wtop = cpu_wdata[BYTE_W-1];

    always_comb begin
        c_d = c_q;
        if (cpu_we && cpu_addr == OFS_CTRL)  c_d.en  = cpu_wdata[ST_EN];
        if (cpu_we && cpu_addr == OFS_SADDR) c_d.own = cpu_wdata[SADDR_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign en       = c_q.en;
    assign own_addr = c_q.own;
    assign tx_wr    = cpu_we && cpu_addr == OFS_TXD;
    assign rx_rd    = cpu_re && cpu_addr == OFS_RXD;
    assign txif_clr = cpu_we && cpu_addr == OFS_CTRL && cpu_wdata[ST_TXIF];

    always_comb begin
        cpu_rdata = '0;
        case (cpu_addr)
            OFS_CTRL: begin
                cpu_rdata[ST_EN]    = c_q.en;
                cpu_rdata[ST_RXBF]  = rxbf;
                cpu_rdata[ST_TXBE]  = txbe;
                cpu_rdata[ST_MATCH] = match;
                cpu_rdata[ST_RXAK]  = rxak;
                cpu_rdata[ST_TXIF]  = txif;
            end
            OFS_SADDR: cpu_rdata[SADDR_W-1:0] = c_q.own;
            OFS_TXD:   cpu_rdata = tx_data;
            default:   cpu_rdata = rx_data;
        endcase
    end
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
    import i2cs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [SADDR_W-1:0] own_addr,
    input  logic               sda_s,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_ev,
    input  logic               stop_ev,
    input  logic               tx_wr,
    input  logic [BYTE_W-1:0]  tx_wdata,
    input  logic               rx_rd,
    input  logic               txif_clr,
    output logic               scl_oe,
    output logic               sda_oe,
    output logic [BYTE_W-1:0]  tx_data,
    output logic [BYTE_W-1:0]  rx_data,
    output logic               txbe,
    output logic               rxbf,
    output logic               match,
    output logic               rxak,
    output logic               txif
);
    localparam logic [CNT_W-1:0] FULL    = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] FULL_M1 = CNT_W'(BYTE_W - 1);

    eng_regs_t         r_d, r_q;
    logic              do_load;
    logic              have_tx;
    logic [BYTE_W-1:0] tx_src;

    always_comb begin
        r_d     = r_q;
        do_load = 1'b0;
        have_tx = tx_wr || !r_q.txbe;
        tx_src  = tx_wr ? tx_wdata : r_q.tx;

        if (tx_wr) begin
            r_d.tx   = tx_wdata;
            r_d.txbe = 1'b0;
        end
        if (rx_rd)    r_d.rxbf = 1'b0;
        if (txif_clr) r_d.txif = 1'b0;

        if (start_ev) begin
            r_d.state = S_ADDR;
            r_d.cnt   = '0;
        end else if (stop_ev) begin
            r_d.state = S_IDLE;
        end else begin
            case (r_q.state)
                S_ADDR, S_RX: begin
                    if (scl_rise && r_q.cnt != FULL) begin
                        r_d.sh  = {r_q.sh[BYTE_W-2:0], sda_s};
                        r_d.cnt = r_q.cnt + 1'b1;
                    end else if (scl_fall && r_q.cnt == FULL) begin
                        if (r_q.state == S_ADDR) begin
                            if (r_q.sh[BYTE_W-1:1] == own_addr) begin
                                r_d.state = S_ADDR_ACK;
                                r_d.rw    = r_q.sh[0];
                                if (!r_q.rxbf) begin
                                    r_d.rx    = r_q.sh;
                                    r_d.rxbf  = 1'b1;
                                    r_d.match = 1'b1;
                                end
                            end else begin
                                r_d.state = S_IDLE;
                            end
                        end else begin
                            r_d.state = S_RX_ACK;
                            if (!r_q.rxbf) begin
                                r_d.rx    = r_q.sh;
                                r_d.rxbf  = 1'b1;
                                r_d.match = 1'b0;
                            end
                        end
                    end
                end
                S_ADDR_ACK: begin
                    if (scl_fall) begin
                        if (r_q.rw) begin
                            if (have_tx) do_load = 1'b1;
                            else         r_d.state = S_HOLD;
                        end else begin
                            r_d.state = S_RX;
                            r_d.cnt   = '0;
                        end
                    end
                end
                S_RX_ACK: begin
                    if (scl_fall) begin
                        r_d.state = S_RX;
                        r_d.cnt   = '0;
                    end
                end
                S_TX: begin
                    if (scl_fall) begin
                        r_d.sh  = {r_q.sh[BYTE_W-2:0], 1'b1};
                        r_d.cnt = r_q.cnt + 1'b1;
                        if (r_q.cnt == FULL_M1) r_d.state = S_TX_ACK;
                    end
                end
                S_TX_ACK: begin
                    if (scl_rise) begin
                        r_d.rxak = sda_s;
                    end else if (scl_fall) begin
                        if (r_q.rxak)  r_d.state = S_IDLE;
                        else if (have_tx) do_load = 1'b1;
                        else           r_d.state = S_HOLD;
                    end
                end
                S_HOLD: begin
                    if (tx_wr) do_load = 1'b1;
                end
                default: ;
            endcase
        end

        if (do_load) begin
            r_d.sh    = tx_src;
            r_d.tx    = tx_src;
            r_d.txbe  = 1'b1;
            r_d.txif  = 1'b1;
            r_d.cnt   = '0;
            r_d.state = S_TX;
        end

        if (!en) begin
            r_d.state = S_IDLE;
            r_d.txbe  = 1'b1;
            r_d.rxbf  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= S_IDLE;
            r_q.tx    <= '1;
            r_q.txbe  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign scl_oe  = r_q.state == S_HOLD;
    assign sda_oe  = r_q.state == S_ADDR_ACK || r_q.state == S_RX_ACK
                  || (r_q.state == S_TX && !r_q.sh[BYTE_W-1]);
    assign tx_data = r_q.tx;
    assign rx_data = r_q.rx;
    assign txbe    = r_q.txbe;
    assign rxbf    = r_q.rxbf;
    assign match   = r_q.match;
    assign rxak    = r_q.rxak;
    assign txif    = r_q.txif;
endmodule

// File: rtl/i2cs_top.sv
module i2cs_top
    import i2cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_we,
    input  logic              cpu_re,
    input  logic [1:0]        cpu_addr,
    input  logic [BYTE_W-1:0] cpu_wdata,
    output logic [BYTE_W-1:0] cpu_rdata,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              tx_irq
);
    logic               en_w, tx_wr_w, rx_rd_w, txif_clr_w;
    logic [SADDR_W-1:0] own_w;
    logic               sda_s_w, rise_w, fall_w, start_w, stop_w;
    logic               txbe_w, rxbf_w, match_w, rxak_w;
    logic [BYTE_W-1:0]  tx_data_w, rx_data_w;

    i2cs_line_mon #(.STAGES(SYNC_STAGES)) u_mon (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s_w), .scl_rise(rise_w), .scl_fall(fall_w),
        .start_ev(start_w), .stop_ev(stop_w)
    );

    i2cs_regs u_regs (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_re(cpu_re),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .txbe(txbe_w), .rxbf(rxbf_w), .match(match_w), .rxak(rxak_w),
        .txif(tx_irq), .tx_data(tx_data_w), .rx_data(rx_data_w),
        .en(en_w), .own_addr(own_w), .cpu_rdata(cpu_rdata),
        .tx_wr(tx_wr_w), .rx_rd(rx_rd_w), .txif_clr(txif_clr_w)
    );

    i2cs_engine u_eng (
        .clk(clk), .rst_n(rst_n), .en(en_w), .own_addr(own_w),
        .sda_s(sda_s_w), .scl_rise(rise_w), .scl_fall(fall_w),
        .start_ev(start_w), .stop_ev(stop_w),
        .tx_wr(tx_wr_w), .tx_wdata(cpu_wdata), .rx_rd(rx_rd_w),
        .txif_clr(txif_clr_w), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .tx_data(tx_data_w), .rx_data(rx_data_w), .txbe(txbe_w),
        .rxbf(rxbf_w), .match(match_w), .rxak(rxak_w), .txif(tx_irq)
    );
endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk
    import i2cs_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              tx_wr,
    input logic              rx_rd,
    input logic              scl_oe,
    input logic              sda_oe,
    input logic              txbe,
    input logic              rxbf,
    input logic              tx_irq,
    input logic [BYTE_W-1:0] rx_data
);
    // R4
    hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_oe && tx_wr) |=> !scl_oe);

    // R4
    hold_sda_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe |-> !sda_oe);

    // R2
    off_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (txbe && !rxbf));

    // R2
    off_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && $past(!en)) |-> (!scl_oe && !sda_oe));

    // R1
    tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && en) |=> (!txbe || tx_irq));

    // R7
    rx_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rxbf && !rx_rd) |=> $stable(rx_data));
endmodule

bind i2cs_top i2cs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .en(en_w), .tx_wr(tx_wr_w), .rx_rd(rx_rd_w),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .txbe(txbe_w), .rxbf(rxbf_w),
    .tx_irq(tx_irq), .rx_data(rx_data_w)
);

// File: tb/i2cs_top_tb_top.sv
module i2cs_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int H = 10;
    localparam int WATCHDOG = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_we = 1'b0, cpu_re = 1'b0;
    logic [1:0] cpu_addr = 2'd0;
    logic [7:0] cpu_wdata = 8'd0;
    logic [7:0] cpu_rdata;
    logic       scl_oe, sda_oe, tx_irq;
    logic       m_scl_low = 1'b0, m_sda_low = 1'b0;
    logic       scl_line, sda_line;

    int n_chk = 0, n_err = 0, cycles = 0;
    bit mon_en = 1'b0;
    logic [7:0] exp_st = 8'h04;

    assign scl_line = !(m_scl_low || scl_oe);
    assign sda_line = !(m_sda_low || sda_oe);

    always #(CLK_PERIOD/2) clk = ~clk;

    i2cs_top dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_re(cpu_re),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .scl_i(scl_line), .sda_i(sda_line), .scl_oe(scl_oe),
        .sda_oe(sda_oe), .tx_irq(tx_irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Per-clock reference comparison of the status byte while bus and CPU are quiet
    always @(posedge clk) begin
        cycles++;
        #(CLK_PERIOD/4);
        if (mon_en && rst_n && cpu_addr == 2'd0 && !cpu_we && !cpu_re)
            check(cpu_rdata == exp_st, "R2/R1 status model", cpu_rdata, exp_st);
        if (cycles > WATCHDOG) begin
            check(1'b0, "watchdog", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model(input logic [7:0] st);
        cyc(2);
        exp_st = st;
        mon_en = 1'b1;
        cyc(3);
    endtask

    task automatic cpu_write(input logic [1:0] a, input logic [7:0] d);
        mon_en = 1'b0;
        cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
        cyc(1);
        cpu_we = 1'b0; cpu_addr = 2'd0;
    endtask

    task automatic cpu_read(input logic [1:0] a, input bit strobe, output logic [7:0] d);
        mon_en = 1'b0;
        cpu_addr = a; cpu_re = strobe;
        #1 d = cpu_rdata;
        cyc(1);
        cpu_re = 1'b0; cpu_addr = 2'd0;
    endtask

    task automatic status_is(input logic [7:0] e, input string req);
        logic [7:0] v;
        cpu_read(2'd0, 1'b0, v);
        check(v == e, req, v, e);
    endtask

    task automatic bus_start();
        mon_en = 1'b0;
        m_sda_low = 1'b0; m_scl_low = 1'b0; cyc(H);
        m_sda_low = 1'b1; cyc(H);
        m_scl_low = 1'b1; cyc(H);
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; cyc(H);
        m_scl_low = 1'b0; cyc(H);
        m_sda_low = 1'b0; cyc(H);
    endtask

    task automatic pulse(output bit smp);
        m_scl_low = 1'b0;
        while (!scl_line) cyc(1);
        cyc(H/2);
        smp = sda_line;
        cyc(H/2);
        m_scl_low = 1'b1;
        cyc(H);
    endtask

    task automatic put_bit(input bit b);
        bit dummy;
        m_sda_low = !b; cyc(H);
        pulse(dummy);
    endtask

    task automatic get_bit(output bit b);
        m_sda_low = 1'b0; cyc(H);
        pulse(b);
    endtask

    task automatic put_byte(input logic [7:0] d, output bit ack);
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(ack);
    endtask

    task automatic get_byte(input bit nack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            bit b;
            get_bit(b);
            d[i] = b;
        end
        put_bit(nack);
    endtask

    initial begin
        logic [7:0] v;
        bit ack;
        cyc(5);
        rst_n = 1'b1;
        cyc(1);
        // R8 reset values
        status_is(8'h04, "R8 status after reset");
        cpu_read(2'd2, 1'b0, v); check(v == 8'hFF, "R8 tx reg reset", v, 8'hFF);
        cpu_read(2'd3, 1'b0, v); check(v == 8'h00, "R8 rx reg reset", v, 8'h00);
        model(8'h04);

        cpu_write(2'd0, 8'h01);
        cpu_write(2'd1, 8'h2A);
        model(8'h05);

        // R3 mismatching address gets no acknowledge
        bus_start();
        put_byte(8'h56, ack);
        check(ack == 1'b1, "R3 mismatch not acknowledged", ack, 1);
        bus_stop();
        status_is(8'h05, "R3 flags unchanged on mismatch");
        model(8'h05);

        // R5 / R7 write direction
        bus_start();
        put_byte(8'h54, ack);
        check(ack == 1'b0, "R3 matching address acknowledged", ack, 0);
        status_is(8'h0F, "R7 address stored with match flag");
        put_byte(8'hA5, ack);
        check(ack == 1'b0, "R5 data byte acknowledged", ack, 0);
        cpu_read(2'd3, 1'b0, v); check(v == 8'h54, "R7 full register not overwritten", v, 8'h54);
        cpu_read(2'd3, 1'b1, v); check(v == 8'h54, "R7 read of address byte", v, 8'h54);
        status_is(8'h0D, "R7 read clears receive-full");
        put_byte(8'h3C, ack);
        check(ack == 1'b0, "R5 second data byte acknowledged", ack, 0);
        status_is(8'h07, "R7 data stored with match flag clear");
        bus_stop();
        cpu_read(2'd3, 1'b1, v); check(v == 8'h3C, "R7 data byte value", v, 8'h3C);
        model(8'h05);

        // R1 / R9 read direction with data ready
        cpu_write(2'd2, 8'h96);
        model(8'h01);
        bus_start();
        put_byte(8'h55, ack);
        check(ack == 1'b0, "R3 read address acknowledged", ack, 0);
        status_is(8'h2F, "R1 load sets empty flag and interrupt");
        check(tx_irq == 1'b1, "R1 tx_irq pin", tx_irq, 1);
        cpu_write(2'd2, 8'hC3);
        status_is(8'h2B, "R1 write clears empty flag");
        get_byte(1'b0, v);
        check(v == 8'h96, "R1 first byte MSB first", v, 8'h96);
        get_byte(1'b0, v);
        check(v == 8'hC3, "R9 reload without hold", v, 8'hC3);
        status_is(8'h2F, "R9 empty after reload");

        // R4 hold SCL when empty, then R6 NACK with a waiting byte
        fork
            get_byte(1'b1, v);
            begin
                cyc(30);
                check(scl_oe == 1'b1 && scl_line == 1'b0, "R4 SCL held low", scl_oe, 1);
                check(sda_oe == 1'b0, "R4 SDA released while holding", sda_oe, 0);
                cpu_write(2'd2, 8'h0F);
                cyc(3);
                check(scl_oe == 1'b0, "R4 SCL released after write", scl_oe, 0);
                cyc(40);
                cpu_write(2'd2, 8'h33);
            end
        join
        check(v == 8'h0F, "R4 written byte sent", v, 8'h0F);
        check(sda_oe == 1'b0, "R6 SDA released after NACK", sda_oe, 0);
        status_is(8'h3B, "R6 empty flag unchanged by NACK");
        bus_stop();
        cpu_read(2'd2, 1'b0, v); check(v == 8'h33, "R6 byte kept", v, 8'h33);
        cpu_read(2'd3, 1'b1, v); check(v == 8'h55, "R7 read address stored", v, 8'h55);
        cpu_write(2'd0, 8'h21);
        model(8'h19);
        bus_start();
        put_byte(8'h55, ack);
        check(ack == 1'b0, "R6 readdress acknowledged", ack, 0);
        get_byte(1'b1, v);
        check(v == 8'h33, "R6 waiting byte sent on next addressing", v, 8'h33);
        bus_stop();
        model(8'h3F);

        // R2 disabled block
        cpu_write(2'd0, 8'h00);
        model(8'h3C);
        cpu_write(2'd2, 8'h44);
        model(8'h3C);
        bus_start();
        put_byte(8'h54, ack);
        check(ack == 1'b1, "R2 no acknowledge while disabled", ack, 1);
        check(!scl_oe && !sda_oe, "R2 lines released while disabled", {scl_oe, sda_oe}, 0);
        bus_stop();
        status_is(8'h3C, "R2 flags while disabled");
        model(8'h3C);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule